// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace words into a circular on-chip RAM. Capture is armed through a control register. Each word presented with the strobe is staged for one cycle and then written at the write pointer, which wraps around the RAM. When the pointer has wrapped at least once, a sticky full flag is set, so the oldest valid entry is the one at the write pointer.

A trigger pulse marks the event of interest. From then on, a programmable post-trigger count is decremented for every accepted word. When it reaches zero, capture stops by itself and an acquisition-complete flag is raised. The RAM then holds the history leading up to the trigger and the chosen amount of history after it.

A debug host reaches nine 32-bit registers through a 40-bit serial frame that uses capture, shift and update strobes. The frame carries a 32-bit data field, a 7-bit register address and a direction bit. A read answers in the data field of the following frame. Reading the RAM data register returns the entry at the read pointer and advances the pointer, so a run of frames addressing that register streams the buffer out in order.

Top module: `trace_capture_buffer`

## Requirements
- R1: After reset, control, status flags, read pointer, write pointer and post-trigger count all read 0, except status bit 3, which reads 1. The register map is:
  - address 0: identification, which returns the constant ID_VALUE (default 32'h0B7C_1A01);
  - address 1: RAM depth, which returns 2**DEPTH_LOG2 (default 64);
  - address 2: RAM width, which returns 32;
  - address 3: status;
  - address 4: RAM data;
  - address 5: read pointer;
  - address 6: write pointer;
  - address 7: post-trigger count;
  - address 8: control.
- R2: A frame is 40 bits, shifted least significant bit first: sc_tdi enters at the top of the shift register on each shift strobe, and sc_tdo presents bit 0. Bits [31:0] are data, bits [38:32] are the register address, and bit 39 is the direction, where 1 means write. An update strobe acts on the frame.
- R3: The value of a read frame is loaded into bits [31:0] at the next capture strobe, so it appears in the following frame. Frames without an update leave that result unchanged.
- R4: A read of address 4 returns the RAM entry at the read pointer and then increments the pointer modulo the depth.
- R5: While control bit 0 is set and capture has not completed, each word strobed by trace_valid is written at the write pointer one cycle later, and the write pointer increments modulo the depth. Status bit 3 (formatter empty) is 0 exactly while an accepted word awaits its RAM write.
- R6: Status bit 0 (full) is set when a word is written at the last RAM location. It stays set until control is written with bit 0 set.
- R7: A trigger_in pulse during capture sets status bit 1. The word strobed with the trigger and exactly N further words are stored, where N is the post-trigger count. Then status bit 2 is set and control bit 0 clears. The count does not change before a trigger.
- R8: Writing control bit 0 to 0 stops capture: later strobes leave the write pointer and the RAM unchanged.
- R9: Writing the write pointer register sets the location of the next stored word. Writing control with bit 0 set clears status bits 0 to 2.
- R10: Writes to addresses 0 to 3 are ignored, and reads of addresses 9 to 127 return 0.
- R11: Control bit 1 (demultiplexed port mode) is stored and read back unchanged, whether or not capture is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trace_valid | input | 1 | Strobe: trace_word is valid this cycle |
| trace_word | input | 32 | Trace word to store |
| trigger_in | input | 1 | Trigger event pulse |
| sc_capture | input | 1 | Load the pending read result into the frame register |
| sc_shift | input | 1 | Shift the frame register one bit |
| sc_update | input | 1 | Execute the frame held in the frame register |
| sc_tdi | input | 1 | Serial data into the frame register |
| sc_tdo | output | 1 | Serial data out, bit 0 of the frame register |

## Verification
A wrong write pointer or a missed wrap shows up in the next readout. The status frame reports the wrong full bit, or the streamed entries start at the wrong location; either is visible about two frames, roughly ninety cycles, after capture ends. A faulty post-trigger count shifts the stop point by whole words, so the write pointer read back differs and the last entries streamed out mismatch the reference ring. A read pointer that fails to advance repeats an entry on the very next data frame. The bench mixes seeded random run lengths, counts and port modes with directed cases for reset values, read-only registers, wrap and stop.

// File: rtl/tcb_pkg.sv
// Shared constants and frame layout for the trace capture buffer.
package tcb_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_FW = 7;
    localparam int FRAME_W = DATA_W + ADDR_FW + 1;

    localparam logic [ADDR_FW-1:0] A_IDENT  = 7'd0;
    localparam logic [ADDR_FW-1:0] A_DEPTH  = 7'd1;
    localparam logic [ADDR_FW-1:0] A_WIDTH  = 7'd2;
    localparam logic [ADDR_FW-1:0] A_STATUS = 7'd3;
    localparam logic [ADDR_FW-1:0] A_DATA   = 7'd4;
    localparam logic [ADDR_FW-1:0] A_RPTR   = 7'd5;
    localparam logic [ADDR_FW-1:0] A_WPTR   = 7'd6;
    localparam logic [ADDR_FW-1:0] A_TCOUNT = 7'd7;
    localparam logic [ADDR_FW-1:0] A_CTRL   = 7'd8;

    localparam int CTRL_RUN   = 0;
    localparam int CTRL_DEMUX = 1;

    // Serial frame: direction on top, then address, then data.
    typedef struct packed {
        logic               write;
        logic [ADDR_FW-1:0] addr;
        logic [DATA_W-1:0]  data;
    } frame_t;
endpackage

// File: rtl/tcb_shift_port.sv
// Serial frame register. Assumes capture, shift and update strobes are
// mutually exclusive single-cycle pulses. Data leaves LSB first on sc_tdo.
module tcb_shift_port
    import tcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              shift,
    input  logic              upd,
    input  logic              tdi,
    input  logic [DATA_W-1:0] load_data,
    output logic              tdo,
    output logic              req_valid,
    output frame_t            req
);
    logic [FRAME_W-1:0] sr_q;

    // Frame register: load read result on capture, shift right on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (cap)
            sr_q <= {{(FRAME_W-DATA_W){1'b0}}, load_data};
        else if (shift)
            sr_q <= {tdi, sr_q[FRAME_W-1:1]};
    end

    assign tdo       = sr_q[0];
    assign req_valid = upd;
    assign req       = frame_t'(sr_q);
endmodule

// File: rtl/tcb_capture.sv
// Capture engine: one-word staging register, circular RAM, write pointer,
// post-trigger countdown, control bits and status flags.
// Assumes DEPTH is a power of two so pointers wrap by overflow.
module tcb_capture
    import tcb_pkg::*;
#(
    parameter int AW    = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_valid,
    input  logic [DATA_W-1:0] trace_word,
    input  logic              trigger_in,
    input  logic              wr_ctrl,
    input  logic              wr_wptr,
    input  logic              wr_tcnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic              run,
    output logic              demux,
    output logic [AW-1:0]     wptr,
    output logic [DATA_W-1:0] tcnt,
    output logic              full,
    output logic              trig,
    output logic              acq,
    output logic              empty
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] stage_q;
    logic              pend_q;
    logic              done_now;
    logic              accept;
    logic              arm;

    assign done_now = trig && (tcnt == '0);
    assign accept   = run && !acq && trace_valid && !done_now;
    assign arm      = wr_ctrl && wdata[CTRL_RUN];

    // Control bits and completion: a register write wins over auto-stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            demux <= 1'b0;
            acq   <= 1'b0;
        end else if (wr_ctrl) begin
            run   <= wdata[CTRL_RUN];
            demux <= wdata[CTRL_DEMUX];
            if (wdata[CTRL_RUN])
                acq <= 1'b0;
        end else if (run && !acq && done_now) begin
            run <= 1'b0;
            acq <= 1'b1;
        end
    end

    // Triggered flag: set by a trigger pulse during capture, cleared on re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig <= 1'b0;
        else if (arm)
            trig <= 1'b0;
        else if (run && !acq && trigger_in)
            trig <= 1'b1;
    end

    // Post-trigger count: loaded by host, decremented per accepted word after trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt <= '0;
        else if (wr_tcnt)
            tcnt <= wdata;
        else if (accept && trig)
            tcnt <= tcnt - 1'b1;
    end

    // Staging register between the strobe and the RAM write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            stage_q <= '0;
        end else begin
            pend_q <= accept;
            if (accept)
                stage_q <= trace_word;
        end
    end

    // Write pointer and wrap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            full <= 1'b0;
        end else begin
            if (wr_wptr)
                wptr <= wdata[AW-1:0];
            else if (pend_q)
                wptr <= wptr + 1'b1;
            if (arm)
                full <= 1'b0;
            else if (pend_q && wptr == LAST)
                full <= 1'b1;
        end
    end

    // Trace RAM write port.
    always_ff @(posedge clk) begin
        if (pend_q)
            mem[wptr] <= stage_q;
    end

    assign rd_word = mem[rd_idx];
    assign empty   = !pend_q;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        acq |-> !run); // R7
    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !wr_tcnt) |=> $stable(tcnt)); // R7
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !arm) |=> full); // R6
    AST_STOPPED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && empty && !wr_wptr) |=> $stable(wptr)); // R8
endmodule

// File: rtl/tcb_regs.sv
// Register decode: read mux, delayed read result, read pointer with
// auto-increment on data reads, and write strobes to the capture engine.
module tcb_regs
    import tcb_pkg::*;
#(
    parameter int          AW       = 6,
    parameter logic [31:0] ID_VALUE = 32'h0B7C_1A01,
    localparam int         DEPTH    = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  frame_t            req,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              run,
    input  logic              demux,
    input  logic [AW-1:0]     wptr,
    input  logic [DATA_W-1:0] tcnt,
    input  logic              full,
    input  logic              trig,
    input  logic              acq,
    input  logic              empty,
    output logic [AW-1:0]     rptr,
    output logic [DATA_W-1:0] result,
    output logic              wr_ctrl,
    output logic              wr_wptr,
    output logic              wr_tcnt,
    output logic [DATA_W-1:0] wdata
);
    logic              do_wr;
    logic              do_rd;
    logic [DATA_W-1:0] rd_val;

    assign do_wr   = req_valid && req.write;
    assign do_rd   = req_valid && !req.write;
    assign wr_ctrl = do_wr && (req.addr == A_CTRL);
    assign wr_wptr = do_wr && (req.addr == A_WPTR);
    assign wr_tcnt = do_wr && (req.addr == A_TCOUNT);
    assign wdata   = req.data;

    // Read mux over the register map; unmapped addresses read zero.
    always_comb begin
        unique case (req.addr)
            A_IDENT:  rd_val = ID_VALUE;
            A_DEPTH:  rd_val = DATA_W'(DEPTH);
            A_WIDTH:  rd_val = DATA_W'(DATA_W);
            A_STATUS: rd_val = {{(DATA_W-4){1'b0}}, empty, acq, trig, full};
            A_DATA:   rd_val = rd_word;
            A_RPTR:   rd_val = {{(DATA_W-AW){1'b0}}, rptr};
            A_WPTR:   rd_val = {{(DATA_W-AW){1'b0}}, wptr};
            A_TCOUNT: rd_val = tcnt;
            A_CTRL:   rd_val = {{(DATA_W-2){1'b0}}, demux, run};
            default:  rd_val = '0;
        endcase
    end

    // Delayed read result, returned in the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (do_rd)
            result <= rd_val;
    end

    // Read pointer: host-writable, advances after each data read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rptr <= '0;
        else if (do_wr && req.addr == A_RPTR)
            rptr <= req.data[AW-1:0];
        else if (do_rd && req.addr == A_DATA)
            rptr <= rptr + 1'b1;
    end

    AST_RPTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && req.addr == A_DATA) |=> (rptr == AW'($past(rptr) + 1'b1))); // R4
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(result)); // R3
endmodule

// File: rtl/trace_capture_buffer.sv
// Top: circular trace capture buffer with a serial register port.
// Assumes the host issues one strobe (capture, shift or update) per cycle.
module trace_capture_buffer
    import tcb_pkg::*;
#(
    parameter int          DEPTH_LOG2 = 6,
    parameter logic [31:0] ID_VALUE   = 32'h0B7C_1A01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trace_valid,
    input  logic [31:0] trace_word,
    input  logic        trigger_in,
    input  logic        sc_capture,
    input  logic        sc_shift,
    input  logic        sc_update,
    input  logic        sc_tdi,
    output logic        sc_tdo
);
    localparam int AW = DEPTH_LOG2;

    frame_t            req;
    logic              req_valid;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] rd_word;
    logic [AW-1:0]     rptr;
    logic [AW-1:0]     wptr;
    logic [DATA_W-1:0] tcnt;
    logic [DATA_W-1:0] wdata;
    logic              run, demux, full, trig, acq, empty;
    logic              wr_ctrl, wr_wptr, wr_tcnt;

    tcb_shift_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (sc_capture),
        .shift     (sc_shift),
        .upd       (sc_update),
        .tdi       (sc_tdi),
        .load_data (result),
        .tdo       (sc_tdo),
        .req_valid (req_valid),
        .req       (req)
    );

    tcb_regs #(.AW(AW), .ID_VALUE(ID_VALUE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req       (req),
        .rd_word   (rd_word),
        .run       (run),
        .demux     (demux),
        .wptr      (wptr),
        .tcnt      (tcnt),
        .full      (full),
        .trig      (trig),
        .acq       (acq),
        .empty     (empty),
        .rptr      (rptr),
        .result    (result),
        .wr_ctrl   (wr_ctrl),
        .wr_wptr   (wr_wptr),
        .wr_tcnt   (wr_tcnt),
        .wdata     (wdata)
    );

    tcb_capture #(.AW(AW)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .trace_valid (trace_valid),
        .trace_word  (trace_word),
        .trigger_in  (trigger_in),
        .wr_ctrl     (wr_ctrl),
        .wr_wptr     (wr_wptr),
        .wr_tcnt     (wr_tcnt),
        .wdata       (wdata),
        .rd_idx      (rptr),
        .rd_word     (rd_word),
        .run         (run),
        .demux       (demux),
        .wptr        (wptr),
        .tcnt        (tcnt),
        .full        (full),
        .trig        (trig),
        .acq         (acq),
        .empty       (empty)
    );
endmodule

// File: tb/trace_capture_buffer_test.sv
module trace_capture_buffer_test;
    localparam int          DEPTH = 64;
    localparam logic [31:0] IDV   = 32'h0B7C_1A01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tv = 1'b0, stream_on = 1'b0, tg = 1'b0;
    logic [31:0] tw = '0;
    logic cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic tdo;
    logic trace_valid;
    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] mref [DEPTH];
    int  mw;
    bit  mfull;

    assign trace_valid = tv | stream_on;
    always #10 clk = ~clk;

    trace_capture_buffer uut (
        .clk(clk), .rst_n(rst_n), .trace_valid(trace_valid), .trace_word(tw),
        .trigger_in(tg), .sc_capture(cap), .sc_shift(shf), .sc_update(upd),
        .sc_tdi(tdi), .sc_tdo(tdo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One 40-bit frame, LSB first; returns the data field shifted out.
    task automatic frame(input bit wr, input int addr, input logic [31:0] data,
                         output logic [31:0] got);
        logic [39:0] f;
        f = {wr, 7'(addr), data};
        got = '0;
        @(negedge clk) cap = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cap = 1'b0;
            if (i < 32) got[i] = tdo;
            tdi = f[i];
            shf = 1'b1;
        end
        @(negedge clk) shf = 1'b0; upd = 1'b1;
        @(negedge clk) upd = 1'b0;
    endtask

    task automatic wr_reg(input int addr, input logic [31:0] data);
        logic [31:0] d;
        frame(1'b1, addr, data, d);
    endtask

    task automatic rd_reg(input int addr, output logic [31:0] v);
        logic [31:0] d;
        frame(1'b0, addr, 32'h0, d);
        frame(1'b0, 0, 32'h0, v);
    endtask

    task automatic push(input logic [31:0] w, input bit trig);
        @(negedge clk) tv = 1'b1; tw = w; tg = trig;
        @(negedge clk) tv = 1'b0; tg = 1'b0;
    endtask

    function automatic int next_ptr(input int p);
        return (p + 1) % DEPTH;
    endfunction

    function automatic logic [31:0] status_word(input bit e, input bit a, input bit t, input bit f);
        return {28'h0, e, a, t, f};
    endfunction

    task automatic model_store(input logic [31:0] w);
        mref[mw] = w;
        if (mw == DEPTH - 1) mfull = 1;
        mw = next_ptr(mw);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, got, w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and fixed registers
        rd_reg(0, v); check("R1 ident", v, IDV);
        rd_reg(1, v); check("R1 depth", v, DEPTH);
        rd_reg(2, v); check("R1 width", v, 32);
        rd_reg(3, v); check("R1 status", v, status_word(1, 0, 0, 0));
        rd_reg(8, v); check("R1 ctrl", v, 0);
        rd_reg(5, v); check("R1 rptr", v, 0);
        rd_reg(6, v); check("R1 wptr", v, 0);
        rd_reg(7, v); check("R1 tcount", v, 0);

        // R2/R3: delayed result; frame after a depth read returns depth, next returns ident
        frame(1'b0, 1, 0, got);
        frame(1'b0, 0, 0, got); check("R3 delayed depth", got, DEPTH);
        frame(1'b0, 0, 0, got); check("R3 ident follows", got, IDV);
        wr_reg(7, 32'hA5C3_1234); rd_reg(7, v); check("R2 write field layout", v, 32'hA5C3_1234);

        // R10: read-only and unmapped
        wr_reg(0, 32'hFFFF_FFFF); rd_reg(0, v); check("R10 ident ro", v, IDV);
        wr_reg(3, 32'hF); rd_reg(3, v); check("R10 status ro", v, status_word(1, 0, 0, 0));
        wr_reg(1, 32'h5); rd_reg(1, v); check("R10 depth ro", v, DEPTH);
        rd_reg(9, v); check("R10 unmapped 9", v, 0);
        rd_reg(127, v); check("R10 unmapped 127", v, 0);

        // R11: demux bit readback while stopped
        wr_reg(8, 32'h2); rd_reg(8, v); check("R11 demux readback", v, 32'h2);
        wr_reg(8, 32'h0);

        // R8: stopped capture ignores strobes
        wr_reg(6, 5);
        push(32'h1111_1111, 0); push(32'h2222_2222, 1);
        rd_reg(6, v); check("R8 wptr unchanged", v, 5);
        rd_reg(3, v); check("R8 no trigger when stopped", v, status_word(1, 0, 0, 0));

        // R9/R7: write pointer placement, count frozen without trigger
        wr_reg(6, 10); wr_reg(7, 1000); wr_reg(8, 1);
        push(32'hCAFE_0001, 0); push(32'hCAFE_0002, 0);
        wr_reg(8, 0);
        rd_reg(6, v); check("R9 wptr advanced", v, 12);
        rd_reg(7, v); check("R7 count frozen", v, 1000);
        wr_reg(5, 10);
        frame(1'b0, 4, 0, got);
        frame(1'b0, 4, 0, got); check("R9 first at 10", got, 32'hCAFE_0001);
        frame(1'b0, 0, 0, got); check("R4 second at 11", got, 32'hCAFE_0002);
        rd_reg(5, v); check("R4 rptr after two", v, 12);

        // R4: read pointer wrap
        wr_reg(5, DEPTH - 1);
        frame(1'b0, 4, 0, got);
        rd_reg(5, v); check("R4 rptr wraps", v, 0);

        // R5: empty low while words stream in
        wr_reg(7, 32'hFFFF); wr_reg(8, 1);
        @(negedge clk) stream_on = 1'b1;
        rd_reg(3, v); check("R5 empty low while pending", {31'h0, v[3]}, 0);
        @(negedge clk) stream_on = 1'b0;
        wr_reg(8, 0);
        rd_reg(3, v); check("R5 empty high when idle", {31'h0, v[3]}, 1);

        // Random runs: R5 R6 R7 R9 R4
        for (int it = 0; it < 4; it++) begin
            int n, k, first, cnt;
            bit dm;
            n  = $urandom_range(0, 6);
            k  = $urandom_range(0, 90);
            dm = it[0];
            wr_reg(7, n); wr_reg(6, 0); wr_reg(8, {30'h0, dm, 1'b1});
            mw = 0; mfull = 0;
            for (int j = 0; j < k; j++) begin
                w = $urandom; push(w, 0); model_store(w);
            end
            w = $urandom; push(w, 1); model_store(w);
            for (int j = 0; j < n + 4; j++) begin
                w = $urandom; push(w, 0);
                if (j < n) model_store(w);
            end
            repeat (4) @(negedge clk);
            rd_reg(3, v); check("R7 R6 status after run", v, status_word(1, 1, 1, mfull));
            rd_reg(8, v); check("R7 run cleared", v, {30'h0, dm, 1'b0});
            rd_reg(6, v); check("R5 R7 wptr after run", v, mw);
            first = mfull ? mw : 0;
            cnt   = mfull ? DEPTH : mw;
            wr_reg(5, first);
            frame(1'b0, 4, 0, got);
            for (int e = 0; e < cnt; e++) begin
                frame(1'b0, (e == cnt - 1) ? 0 : 4, 0, got);
                check("R4 R5 ring entry", got, mref[(first + e) % DEPTH]);
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule